// File: doc/BRIEF.md
# Byte-Buffered 16-bit Timer/Event Counter

This block is a 16-bit up-counter paired with a 16-bit reload value. Software reaches both over an 8-bit register bus. Byte buffers on each side make every 16-bit transfer atomic:

- **Writes.** A write to the low reload byte is held in a staging byte. Only the write to the high reload byte moves the full word into the reload register.
- **Reads.** A read of the counter's high byte returns the live high byte. In the same cycle it freezes the live low byte into a capture byte, and a later low-byte read returns that capture byte.

A control register picks what advances the counter, and the counter always continues upward from the value it holds:

- **Pin events:** rising or falling edges on an external pin.
- **Converter clock:** edges of an external A/D conversion clock.
- **Internal time base:** the system clock, the system clock divided by four, or a one-cycle real-time tick.
- **Pulse-width measurement:** counting at a quarter of the system clock while the pin stays at a chosen level.

When the count passes 0xFFFF it reloads, raises a sticky flag, pulses an interrupt for one cycle and toggles a frequency output. A bit in a separate converter-control register turns the whole counting function off.

Top module: `tmr16_bytebus`

Register map, as byte addresses on `busAddr`:

| Address | Register | Access |
|---|---|---|
| 0x20 | counter high byte | read |
| 0x21 | counter low byte | read |
| 0x22 | control | read/write |
| 0x23 | reload high byte | write |
| 0x24 | reload low byte | write |
| 0x25 | converter control | read/write |

Control register fields:

| Bits | Field | Meaning |
|---|---|---|
| [2:0] | mode | 1 pin events, 2 converter clock, 3 internal time base, 4 pulse width; any other value does not count |
| [3] | edge | 0 selects rising edges or a high level, 1 selects falling edges or a low level |
| [4] | enable | counting enable |
| [6:5] | time base | 0 or 3 system clock, 1 system clock divided by four, 2 real-time tick |
| [7] | flag | reads the overflow flag; writing 1 clears it |

## Requirements
- R1: A write to address 0x24 changes only the staging byte; the reload register keeps its value until a write to 0x23.
- R2: A write to 0x23 loads {written byte, staging byte} into the 16-bit reload register in that same cycle.
- R3: A read of 0x20 returns the live counter high byte and captures the live counter low byte into the capture byte on that clock edge.
- R4: A read of 0x21 returns the capture byte, not the live counter low byte.
- R5: While bit 1 of the converter-control register (0x25) is 1, the counter holds its value whatever the control register says.
- R6: In mode 3 the counter advances once per cycle for time base 0 or 3, once every fourth cycle for time base 1, and once per real-time tick pulse for time base 2.
- R7: In mode 1 the counter advances once per edge of the external pin, after a two-flop synchroniser; edge bit 0 counts rising edges and edge bit 1 counts falling edges.
- R8: In mode 2 the counter advances once per selected edge of the converter clock pin, after a two-flop synchroniser.
- R9: In mode 4 the counter advances once every fourth cycle while the synchronised pin is at the selected level. When that level ends, the enable bit (control bit 4) is cleared, so the count stays frozen until software sets the bit again.
- R10: When counting stops and restarts, the counter resumes upward from the value it holds, with no reset.
- R11: An increment from 0xFFFF loads the reload value, sets the overflow flag, drives `ovfIrq` high for exactly that one cycle and toggles `freqOut`.
- R12: After reset the counter, reload value, flag, interrupt and `freqOut` are all 0. Writing the control register with bit 7 = 1 clears the flag, and reading the control register returns the flag in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (needed for the read-capture side effect) |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed register (combinational) |
| extPin | input | 1 | External event / pulse-width input, asynchronous |
| adcClkPin | input | 1 | External converter clock input, asynchronous |
| rtcTick | input | 1 | One-cycle real-time tick, synchronous to `clk` |
| ovfFlag | output | 1 | Sticky overflow flag |
| ovfIrq | output | 1 | One-cycle overflow interrupt |
| freqOut | output | 1 | Toggles on each overflow |

## Verification
A corrupted staging or capture byte appears at the very next low-byte access. It shows either as a wrong reload value after the following wrap, or as a fresh instead of stale value on a low-byte read. A wrong count source or gating leaves a count that is off by a predictable amount, and the bench reads that count back through the byte pair after each stimulus window of a few dozen cycles. Failures in overflow handling show within one cycle of the wrap, through the interrupt width, the flag and the reload value read back immediately after.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_EVENT  = 3'd1,
    MODE_ADCCLK = 3'd2,
    MODE_TIMER  = 3'd3,
    MODE_PULSE  = 3'd4
  } tmrMode_e;

  typedef enum logic [1:0] {
    CLK_SYS     = 2'd0,
    CLK_QUARTER = 2'd1,
    CLK_RTC     = 2'd2,
    CLK_SYS_ALT = 2'd3
  } clkSrc_e;

  // Register offsets from the base address.
  localparam int OFS_CNT_HI = 0;
  localparam int OFS_CNT_LO = 1;
  localparam int OFS_CTRL   = 2;
  localparam int OFS_PRE_HI = 3;
  localparam int OFS_PRE_LO = 4;
  localparam int OFS_CONV   = 5;

  // Control register bit positions.
  localparam int CB_EDGE   = 3;
  localparam int CB_EN     = 4;
  localparam int CB_CLK_LO = 5;
  localparam int CB_FLAG   = 7;
  localparam int CONV_SEL  = 1;

  // Strobes and settings from control to datapath.
  typedef struct packed {
    logic     run;
    tmrMode_e mode;
    logic     edgeSel;
    clkSrc_e  clkSel;
  } tmrCmd_t;

  // Events from datapath back to control.
  typedef struct packed {
    logic wrap;
    logic pwEnd;
  } tmrEvt_t;

endpackage

// File: rtl/tmr16_sync.sv
module tmr16_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shReg;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (!rstN) shReg <= '0;
        else       shReg <= d;
      end
    end else begin : gChain
      always_ff @(posedge clk) begin
        if (!rstN) shReg <= '0;
        else       shReg <= {shReg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = shReg[STAGES-1];
endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
#(
  parameter int                 BUS_W     = 8,
  parameter int                 ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h20,
  localparam int                CNT_W     = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [CNT_W-1:0]  count,
  input  tmrEvt_t           evt,
  output tmrCmd_t           cmd,
  output logic [CNT_W-1:0]  preload,
  output logic              ovfFlag
);
  logic [ADDR_W-1:0] relAddr;
  logic              wrCtrl, wrPreHi, wrPreLo, wrConv, rdCntHi;
  logic [6:0]        ctrlReg;
  logic [BUS_W-1:0]  convReg;
  logic [BUS_W-1:0]  wrBuf;
  logic [BUS_W-1:0]  rdBuf;

  assign relAddr = busAddr - BASE_ADDR;
  assign wrCtrl  = busWr && (relAddr == ADDR_W'(OFS_CTRL));
  assign wrPreHi = busWr && (relAddr == ADDR_W'(OFS_PRE_HI));
  assign wrPreLo = busWr && (relAddr == ADDR_W'(OFS_PRE_LO));
  assign wrConv  = busWr && (relAddr == ADDR_W'(OFS_CONV));
  assign rdCntHi = busRd && (relAddr == ADDR_W'(OFS_CNT_HI));

  // Control register: software write wins over the pulse-width end strobe.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrCtrl) begin
      ctrlReg <= busWdata[6:0];
    end else if (evt.pwEnd) begin
      ctrlReg[CB_EN] <= 1'b0;
    end
  end

  // Overflow flag: a wrap wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else if (evt.wrap) begin
      ovfFlag <= 1'b1;
    end else if (wrCtrl && busWdata[CB_FLAG]) begin
      ovfFlag <= 1'b0;
    end
  end

  // Byte buffers, reload register and converter control.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      convReg <= '0;
      wrBuf   <= '0;
      rdBuf   <= '0;
      preload <= '0;
    end else begin
      if (wrConv)  convReg <= busWdata;
      if (wrPreLo) wrBuf   <= busWdata;
      if (wrPreHi) preload <= {busWdata, wrBuf};
      if (rdCntHi) rdBuf   <= count[BUS_W-1:0];
    end
  end

  always_comb begin
    cmd.run     = ctrlReg[CB_EN] && !convReg[CONV_SEL];
    cmd.mode    = tmrMode_e'(ctrlReg[2:0]);
    cmd.edgeSel = ctrlReg[CB_EDGE];
    cmd.clkSel  = clkSrc_e'(ctrlReg[CB_CLK_LO+1:CB_CLK_LO]);
  end

  always_comb begin
    busRdata = '0;
    if      (relAddr == ADDR_W'(OFS_CNT_HI)) busRdata = count[CNT_W-1:BUS_W];
    else if (relAddr == ADDR_W'(OFS_CNT_LO)) busRdata = rdBuf;
    else if (relAddr == ADDR_W'(OFS_CTRL))   busRdata = {ovfFlag, ctrlReg};
    else if (relAddr == ADDR_W'(OFS_CONV))   busRdata = convReg;
  end

  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrPreHi |=> $stable(preload)); // R1
  AST_PRELOAD_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    wrPreHi |=> preload == {$past(busWdata), $past(wrBuf)}); // R2
  AST_RDBUF_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    rdCntHi |=> rdBuf == $past(count[BUS_W-1:0])); // R3
  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    evt.wrap |=> ovfFlag); // R11
endmodule

// File: rtl/tmr16_dp.sv
module tmr16_dp
  import tmr16_pkg::*;
#(
  parameter int  CNT_W       = 16,
  parameter int  PRESC_W     = 2,
  parameter int  SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCmd_t          cmd,
  input  logic [CNT_W-1:0] preload,
  input  logic             extPin,
  input  logic             adcClkPin,
  input  logic             rtcTick,
  output logic [CNT_W-1:0] count,
  output tmrEvt_t          evt,
  output logic             ovfIrq,
  output logic             freqOut
);
  logic               extS, adcS, extD, adcD;
  logic [PRESC_W-1:0] presc;
  logic               quarterTick, timerTick;
  logic               extEdge, adcEdge, levelOn, levelEnd, inc;

  tmr16_sync #(.STAGES(SYNC_STAGES)) uSyncExt (
    .clk(clk), .rstN(rstN), .d(extPin), .q(extS));
  tmr16_sync #(.STAGES(SYNC_STAGES)) uSyncAdc (
    .clk(clk), .rstN(rstN), .d(adcClkPin), .q(adcS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extD  <= 1'b0;
      adcD  <= 1'b0;
      presc <= '0;
    end else begin
      extD  <= extS;
      adcD  <= adcS;
      presc <= presc + 1'b1;
    end
  end

  assign quarterTick = &presc;

  always_comb begin
    extEdge  = cmd.edgeSel ? (extD & ~extS) : (~extD & extS);
    adcEdge  = cmd.edgeSel ? (adcD & ~adcS) : (~adcD & adcS);
    levelOn  = cmd.edgeSel ? ~extS : extS;
    levelEnd = cmd.edgeSel ? (~extD & extS) : (extD & ~extS);
    unique case (cmd.clkSel)
      CLK_QUARTER: timerTick = quarterTick;
      CLK_RTC:     timerTick = rtcTick;
      default:     timerTick = 1'b1;
    endcase
    case (cmd.mode)
      MODE_EVENT:  inc = extEdge;
      MODE_ADCCLK: inc = adcEdge;
      MODE_TIMER:  inc = timerTick;
      MODE_PULSE:  inc = levelOn & quarterTick;
      default:     inc = 1'b0;
    endcase
    evt.wrap  = cmd.run && inc && (count == '1);
    evt.pwEnd = cmd.run && (cmd.mode == MODE_PULSE) && levelEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      ovfIrq  <= 1'b0;
      freqOut <= 1'b0;
    end else begin
      ovfIrq <= evt.wrap;
      if (evt.wrap) freqOut <= ~freqOut;
      if (cmd.run && inc) count <= evt.wrap ? preload : count + 1'b1;
    end
  end

  AST_STILL_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.run |=> $stable(count)); // R5
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && inc && count != '1) |=> count == CNT_W'($past(count) + 1'b1)); // R10
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    evt.wrap |=> (count == $past(preload)) && ovfIrq); // R11
  AST_PW_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && cmd.mode == MODE_PULSE && !levelOn) |=> $stable(count)); // R9
endmodule

// File: rtl/tmr16_bytebus.sv
module tmr16_bytebus
  import tmr16_pkg::*;
#(
  parameter int                BUS_W       = 8,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h20,
  parameter int                PRESC_W     = 2,
  parameter int                SYNC_STAGES = 2,
  localparam int               CNT_W       = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              extPin,
  input  logic              adcClkPin,
  input  logic              rtcTick,
  output logic              ovfFlag,
  output logic              ovfIrq,
  output logic              freqOut
);
  tmrCmd_t          cmd;
  tmrEvt_t          evt;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] preload;

  tmr16_ctrl #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .count(count), .evt(evt),
    .cmd(cmd), .preload(preload), .ovfFlag(ovfFlag));

  tmr16_dp #(.CNT_W(CNT_W), .PRESC_W(PRESC_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .preload(preload), .extPin(extPin),
    .adcClkPin(adcClkPin), .rtcTick(rtcTick), .count(count), .evt(evt),
    .ovfIrq(ovfIrq), .freqOut(freqOut));
endmodule

// File: tb/sim_tmr16_bytebus.sv
module sim_tmr16_bytebus;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0;
  logic [7:0] busRdata;
  logic       extPin = 1'b0, adcClkPin = 1'b0, rtcTick = 1'b0;
  logic       ovfFlag, ovfIrq, freqOut;

  int errors = 0;
  int checks = 0;
  logic [15:0] expCnt;

  logic [7:0] expQ[$];
  string      tagQ[$];
  event       sampleEv;

  always #4 clk = ~clk;  // 125 MHz

  tmr16_bytebus u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extPin(extPin),
    .adcClkPin(adcClkPin), .rtcTick(rtcTick), .ovfFlag(ovfFlag),
    .ovfIrq(ovfIrq), .freqOut(freqOut));

  // Monitor: pops expected read data and compares.
  initial begin
    forever begin
      @(sampleEv);
      checks++;
      if (busRdata !== expQ[0]) begin
        errors++;
        $display("FAIL %s: read addr %02h got %02h expected %02h",
                 tagQ[0], busAddr, busRdata, expQ[0]);
      end
      void'(expQ.pop_front());
      void'(tagQ.pop_front());
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // All drivers are entered just after a falling edge.
  task automatic writeReg(logic [7:0] a, logic [7:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readReg(logic [7:0] a, logic [7:0] exp, string tag);
    busRd = 1'b1; busAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    #2 -> sampleEv;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic readCount(logic [15:0] exp, string tag);
    readReg(8'h20, exp[15:8], tag);
    readReg(8'h21, exp[7:0], tag);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pinPulses(int n, bit adcSide);
    for (int i = 0; i < n; i++) begin
      if (adcSide) adcClkPin = 1'b1; else extPin = 1'b1;
      idle(4);
      if (adcSide) adcClkPin = 1'b0; else extPin = 1'b0;
      idle(4);
    end
  endtask

  // Watchdog
  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    bit seen;
    logic foutBefore;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R12 reset state
    chk("R12 flag", 16'(ovfFlag), 0);
    chk("R12 irq", 16'(ovfIrq), 0);
    chk("R12 freqOut", 16'(freqOut), 0);
    readCount(16'h0000, "R12");
    readReg(8'h22, 8'h00, "R12 ctrl");

    // R6 system clock: 10 idle cycles give 11 increments
    writeReg(8'h22, 8'h13); idle(10); writeReg(8'h22, 8'h03);
    expCnt = 16'd11; readCount(expCnt, "R6 sys");

    // R6 divide by four: 40 counting edges -> 10
    writeReg(8'h22, 8'h33); idle(39); writeReg(8'h22, 8'h03);
    expCnt += 10; readCount(expCnt, "R6 quarter / R10 resume");

    // R6 real-time tick: 5 pulses
    writeReg(8'h22, 8'h53);
    for (int i = 0; i < 5; i++) begin
      rtcTick = 1'b1; idle(1); rtcTick = 1'b0; idle(2);
    end
    writeReg(8'h22, 8'h03);
    expCnt += 5; readCount(expCnt, "R6 rtc");

    // R3 / R4 capture behaviour
    readReg(8'h20, expCnt[15:8], "R3 high");
    writeReg(8'h22, 8'h13); idle(3); writeReg(8'h22, 8'h03);
    readReg(8'h21, expCnt[7:0], "R4 stale low");
    expCnt += 4;
    readCount(expCnt, "R3 fresh");

    // R7 rising edges
    writeReg(8'h22, 8'h11); pinPulses(3, 1'b0); idle(6); writeReg(8'h22, 8'h01);
    expCnt += 3; readCount(expCnt, "R7 rising");

    // R7 falling edges: two full pulses plus a lone rise
    writeReg(8'h22, 8'h19); pinPulses(2, 1'b0);
    extPin = 1'b1; idle(6); writeReg(8'h22, 8'h09);
    extPin = 1'b0; idle(6);
    expCnt += 2; readCount(expCnt, "R7 falling");

    // R8 converter clock
    writeReg(8'h22, 8'h12); pinPulses(4, 1'b1); idle(6); writeReg(8'h22, 8'h02);
    expCnt += 4; readCount(expCnt, "R8 adc clock");

    // R5 converter function selected: no counting
    writeReg(8'h25, 8'h02); readReg(8'h25, 8'h02, "R5 conv reg");
    writeReg(8'h22, 8'h13); idle(10); writeReg(8'h22, 8'h03);
    readCount(expCnt, "R5 held");
    writeReg(8'h25, 8'h00);

    // R9 pulse width, high level for exactly 40 cycles
    writeReg(8'h22, 8'h14); idle(3);
    extPin = 1'b1; idle(40); extPin = 1'b0; idle(8);
    expCnt += 10; readCount(expCnt, "R9 width");
    readReg(8'h22, 8'h04, "R9 enable cleared");
    extPin = 1'b1; idle(20); extPin = 1'b0; idle(6);
    readCount(expCnt, "R9 frozen");

    // R1 / R2 reload setup: 0xFFF0, then a lone low write
    writeReg(8'h24, 8'hF0); writeReg(8'h23, 8'hFF); writeReg(8'h24, 8'h00);
    foutBefore = freqOut;
    chk("R11 freqOut before", 16'(foutBefore), 0);

    // R11 overflow
    writeReg(8'h22, 8'h13);
    seen = 1'b0;
    for (int i = 0; i < 70000 && !seen; i++) begin
      if (ovfIrq) seen = 1'b1; else idle(1);
    end
    chk("R11 irq seen", 16'(seen), 1);
    chk("R11 freqOut toggled", 16'(freqOut), 1);
    writeReg(8'h22, 8'h03);
    chk("R11 irq one cycle", 16'(ovfIrq), 0);
    chk("R11 flag set", 16'(ovfFlag), 1);
    readCount(16'hFFF1, "R1 R2 reload value");
    readReg(8'h22, 8'h83, "R12 flag in ctrl");
    writeReg(8'h22, 8'h83);
    chk("R12 flag cleared", 16'(ovfFlag), 0);
    readReg(8'h22, 8'h03, "R12 ctrl after clear");

    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule